// File: doc/BRIEF.md
# Split-Issue Latency-Hiding Adder Unit

This block is an arithmetic unit that sits on the slot bus of a processor whose only instruction copies a value from one slot to another. It responds to three slot codes. Two of them are operand slots, and the third is a result slot. A move into the second operand slot starts an add that needs a fixed number of cycles. While the add runs, the sequencer keeps issuing unrelated moves.

Writes into the unit never hold up the mover. A move out of the result slot can be placed anywhere later in the program. If the sum is not ready yet, the read port drops its ready line only for the cycles the computation still needs. If the sum is already available, the read is accepted in the same cycle. Software can therefore hide the latency by scheduling independent moves between issue and retrieve.

Top module: `slot_adder_unit`

## Requirements
- R1: Synchronous active-high `rst` leaves the unit idle, with `busy` = 0, `rd_data` = 0 and `rd_ready` = 1.
- R2: A write with `wr_addr` = 0 latches the first operand. It does not start a computation, so `busy` stays 0 and `rd_data` is unchanged.
- R3: A write with `wr_addr` = 1 latches the second operand and launches a computation. `busy` is then high for exactly `LATENCY` cycles after the launching edge.
- R4: When `busy` falls, `rd_data` equals (first operand + second operand) modulo 2^`DATA_W`.
- R5: If a result read (`rd_req` = 1) is raised k cycles after launch with k < `LATENCY`, `rd_ready` stays low for exactly `LATENCY` − k sampled cycles and then rises.
- R6: A result read raised at least `LATENCY` cycles after launch sees `rd_ready` = 1 at once.
- R7: `rd_data` changes only when a computation completes. Repeated reads return the same sum without stalling.
- R8: An operand write (either slot) while `busy` abandons the running add. The count restarts at `LATENCY` and the result is taken from the new operand pair.
- R9: Writes with `wr_addr` = 2 or 3 are ignored. They change neither operand, nor `busy`, nor `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A move is writing into the unit this cycle |
| wr_addr | input | 2 | Destination slot code: 0 first operand, 1 second operand (launch), 2/3 no effect |
| wr_data | input | DATA_W | Value being moved in |
| rd_req | input | 1 | A move is reading the result slot |
| rd_ready | output | 1 | Low while a result read must stall |
| rd_data | output | DATA_W | Result register |
| busy | output | 1 | An add is in flight |

## Verification
The hardest case to reach from the ports is a restart: an operand write must land while an add is still counting. The bench then has to show that the old result stays on `rd_data`, that the stall is measured from the restart and not from the first launch, and that the sum uses the mixed operand pair. The stimulus launches an add, waits a few cycles, writes a new first operand, and tracks `busy` and `rd_data` on every cycle until completion. Stall lengths are measured by raising a read at chosen offsets after launch, from zero up to beyond the latency, and counting the cycles with `rd_ready` low.

// File: rtl/sau_pkg.sv
package sau_pkg;
  typedef enum logic [1:0] {
    SLOT_OPND_X = 2'd0,
    SLOT_OPND_Y = 2'd1,
    SLOT_SPARE0 = 2'd2,
    SLOT_SPARE1 = 2'd3
  } sau_slot_e;
endpackage

// File: rtl/sau_operand_regs.sv
module sau_operand_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_x,
  input  logic              take_y,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] opnd_x,
  output logic [DATA_W-1:0] opnd_y
);
  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_x <= '0;
      opnd_y <= '0;
    end else begin
      if (take_x) opnd_x <= din;
      if (take_y) opnd_y <= din;
    end
  end

  assert_x_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !take_x |=> $stable(opnd_x));
endmodule

// File: rtl/sau_latency_timer.sv
module sau_latency_timer #(
  parameter int LATENCY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy,
  output logic finish
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LATENCY);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)              remain <= '0;
    else if (load)        remain <= RELOAD;
    else if (remain != 0) remain <= remain - LAST;
  end

  assign busy   = (remain != '0);
  assign finish = (remain == LAST) && !load;

  assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> remain == RELOAD);
  assert_count_down_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !load) |=> remain == CNT_W'($past(remain) - LAST));
endmodule

// File: rtl/sau_result_reg.sv
module sau_result_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] sum_in,
  output logic [DATA_W-1:0] result
);
  always_ff @(posedge clk) begin
    if (rst)          result <= '0;
    else if (capture) result <= sum_in;
  end

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(result));
endmodule

// File: rtl/slot_adder_unit.sv
module slot_adder_unit #(
  parameter int DATA_W  = 32,
  parameter int LATENCY = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  import sau_pkg::*;

  function automatic logic [DATA_W-1:0] sau_sum(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  logic              hit_x, hit_y, launch, restart, reload, done_evt;
  logic [DATA_W-1:0] opnd_x, opnd_y, sum_now;

  assign hit_x   = wr_valid && (sau_slot_e'(wr_addr) == SLOT_OPND_X);
  assign hit_y   = wr_valid && (sau_slot_e'(wr_addr) == SLOT_OPND_Y);
  assign launch  = hit_y;
  assign restart = hit_x && busy;
  assign reload  = launch || restart;
  assign sum_now = sau_sum(opnd_x, opnd_y);

  sau_operand_regs #(.DATA_W(DATA_W)) opnd_i (
    .clk(clk), .rst(rst), .take_x(hit_x), .take_y(hit_y),
    .din(wr_data), .opnd_x(opnd_x), .opnd_y(opnd_y));

  sau_latency_timer #(.LATENCY(LATENCY)) timer_i (
    .clk(clk), .rst(rst), .load(reload), .busy(busy), .finish(done_evt));

  sau_result_reg #(.DATA_W(DATA_W)) res_i (
    .clk(clk), .rst(rst), .capture(done_evt), .sum_in(sum_now), .result(rd_data));

  assign rd_ready = !(rd_req && busy);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && rd_data == '0));
  assert_launch_busy_R3: assert property (@(posedge clk) disable iff (rst)
    launch |=> busy);
  assert_sum_on_done_R4: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> rd_data == $past(sum_now));
  assert_idle_x_no_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (hit_x && !busy) |=> !busy);
  assert_spare_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr[1] && !busy) |=> !busy);
endmodule

// File: tb/slot_adder_unit_tb_top.sv
module slot_adder_unit_tb_top;
  localparam int DW  = 32;
  localparam int LAT = 8;

  logic          clk = 0;
  logic          rst = 1;
  logic          wr_valid = 0;
  logic [1:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_req = 0;
  logic          rd_ready, busy;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  slot_adder_unit #(.DATA_W(DW), .LATENCY(LAT)) dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req), .rd_ready(rd_ready),
    .rd_data(rd_data), .busy(busy));

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor: every accepted read pops the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_req && rd_ready) begin
      if (exp_q.size() == 0) check("R7 unexpected read", 1, 0);
      else check("R4 read data", rd_data, exp_q.pop_front());
    end
  end

  task automatic mv_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  // Read k cycles after the last write; push expected sum and stall length
  task automatic mv_read(input int k, input logic [DW-1:0] exp, input int exp_stall,
                         input string req);
    int stall = 0;
    repeat (k) @(posedge clk);
    #1;
    exp_q.push_back(exp);
    rd_req = 1;
    forever begin
      @(negedge clk);
      if (rd_ready) break;
      stall++;
    end
    check(req, stall, exp_stall);
    @(posedge clk); #1;
    rd_req = 0;
  endtask

  task automatic count_busy(input int exp, input string req);
    int n = 0;
    forever begin
      @(negedge clk);
      if (!busy) break;
      n++;
    end
    check(req, n, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 rd_ready", rd_ready, 1);

    // R2: first operand alone does not launch
    mv_write(2'd0, 32'd10);
    @(negedge clk);
    check("R2 busy", busy, 0);
    check("R2 rd_data", rd_data, 0);

    // R3 launch and busy length, R4 sum
    mv_write(2'd1, 32'd25);
    count_busy(LAT, "R3 busy cycles");
    check("R4 sum", rd_data, 35);

    // R5: read at various offsets
    for (int k = 0; k < LAT; k += 3) begin
      mv_write(2'd0, DW'(k));
      mv_write(2'd1, 32'd100);
      mv_read(k, DW'(k + 100), LAT - k, "R5 stall");
    end

    // R6: late read returns at once
    mv_write(2'd0, 32'hFFFF_FFFF);
    mv_write(2'd1, 32'd2);
    mv_read(LAT + 2, 32'd1, 0, "R6 stall");

    // R7: repeated reads, same data, no stall
    mv_read(0, 32'd1, 0, "R7 stall");
    mv_read(1, 32'd1, 0, "R7 stall again");

    // R8: restart while busy, old result held meanwhile
    mv_write(2'd0, 32'd5);
    mv_write(2'd1, 32'd7);
    repeat (3) @(posedge clk);
    #1;
    mv_write(2'd0, 32'd100);
    held = rd_data;
    count_busy(LAT, "R8 busy after restart");
    check("R8 held before done", held, 1);
    check("R8 restarted sum", rd_data, 107);

    // R9: spare slots ignored
    mv_write(2'd2, 32'd999);
    mv_write(2'd3, 32'd888);
    @(negedge clk);
    check("R9 busy", busy, 0);
    check("R9 rd_data", rd_data, 107);
    mv_write(2'd1, 32'd1);
    mv_read(0, 32'd101, LAT, "R9 operand x kept");

    repeat (2) @(posedge clk);
    check("R7 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule